// File: doc/BRIEF.md
# Mode-Controlled Integer ALU

This block is a purely combinational arithmetic and logic unit for the execute stage of a simple integer pipeline. It takes two operands and a 4-bit operation code. It returns a result word, a carry flag and a signed-overflow flag. The operations are:

- signed and unsigned addition and subtraction;
- the bitwise operations AND, OR, XOR and NOR;
- signed and unsigned set-less-than.

Any immediate has already been turned into a full-width operand before it reaches the unit. Multiply, divide and shifts are handled elsewhere.

The datapath is a row of identical bit slices. Each slice holds a full adder, the bitwise gates and an output selector. A small decoder turns the operation code into a few controls: operand inversion, carry-in, result inversion and slice pick. Subtraction and both comparisons reuse the one adder, fed with the inverted second operand and a carry-in of one. A unit at the most significant bit derives the overflow and the less-than decision from the carries around the top slice.

Top module: `int_alu`

## Requirements
- R1: Code 0 (signed add) and code 1 (unsigned add) give result = (A + B) mod 2^32, with carry = bit 32 of the 33-bit unsigned sum.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) give result = (A + ~B + 1) mod 2^32, with carry = bit 32 of that 33-bit sum. The carry is 1 exactly when A >= B as unsigned values.
- R3: For code 0, overflow is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it. Operands of mixed sign never overflow. For code 2, overflow is 1 exactly when A and B differ in sign and the result's sign differs from A's.
- R4: Codes 1 and 3 always drive overflow to 0.
- R5: Code 10 (signed less-than) gives result 1 when A < B as two's complement values and 0 otherwise. Bits 31..1 are zero. The answer is correct when A - B overflows.
- R6: Code 11 (unsigned less-than) gives result 1 when A < B as unsigned values and 0 otherwise. Bits 31..1 are zero.
- R7: Codes 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT(A OR B) bit by bit, with carry and overflow both 0.
- R8: Codes 10 and 11 drive carry and overflow to 0.
- R9: Codes 8, 9, 12, 13, 14 and 15 give result 0 with carry and overflow both 0, whatever the operands.
- R10: The unit holds no state. All outputs follow a change of any input within the same clock cycle, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | First operand (A) |
| op_b_i | input | 32 | Second operand (B) |
| mode_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Carry out of the top bit for add and subtract codes |
| ovf_o | output | 1 | Two's complement overflow for the signed add and subtract codes |

## Verification
Every result, carry and overflow value is due in the same cycle as the operands and operation code that produce it: zero cycles of latency, since there are no registers on any path.

The bench applies each stimulus just after a rising clock edge and samples the outputs at the following falling edge, half a period later. One directed check samples only 1 ns after the inputs change, to show the outputs do not wait for a clock.

The stimulus covers a fixed vector table with hand-computed answers and a sweep of the corner operands (0, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) through every code. Random operands are then compared against an independent 33-bit reference model.

// File: rtl/int_alu_pkg.sv
// Package: shared operation codes and slice control types for int_alu.
// Assumes a 4-bit operation code; the codes below are fixed by the ISA decode.
package int_alu_pkg;

    localparam int MODE_W = 4;

    // Operation codes seen on mode_i.
    localparam logic [MODE_W-1:0] OP_ADD  = 4'd0;
    localparam logic [MODE_W-1:0] OP_ADDU = 4'd1;
    localparam logic [MODE_W-1:0] OP_SUB  = 4'd2;
    localparam logic [MODE_W-1:0] OP_SUBU = 4'd3;
    localparam logic [MODE_W-1:0] OP_AND  = 4'd4;
    localparam logic [MODE_W-1:0] OP_OR   = 4'd5;
    localparam logic [MODE_W-1:0] OP_XOR  = 4'd6;
    localparam logic [MODE_W-1:0] OP_NOR  = 4'd7;
    localparam logic [MODE_W-1:0] OP_SLT  = 4'd10;
    localparam logic [MODE_W-1:0] OP_SLTU = 4'd11;

    // What each bit slice routes to its output.
    typedef enum logic [2:0] {
        PICK_SUM  = 3'd0,
        PICK_AND  = 3'd1,
        PICK_OR   = 3'd2,
        PICK_XOR  = 3'd3,
        PICK_LESS = 3'd4,
        PICK_ZERO = 3'd5
    } slice_pick_e;

    // Controls fanned out from the decoder.
    typedef struct packed {
        logic        inv_b;       // complement B before the adder
        logic        carry_in;    // carry into bit 0
        logic        inv_out;     // complement the picked slice output
        slice_pick_e pick;        // slice output selector
        logic        ovf_vis;     // overflow flag is reported
        logic        carry_vis;   // carry flag is reported
        logic        signed_cmp;  // less-than uses signed rule
    } alu_ctrl_t;

endpackage

// File: rtl/int_alu_dec.sv
// Module: int_alu_dec
// Turns the 4-bit operation code into the slice and flag controls.
// Assumes nothing about the operands; unknown codes select a zero result.
module int_alu_dec
    import int_alu_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output alu_ctrl_t         ctrl_o
);

    // Decode the operation code into control fields.
    always_comb begin
        ctrl_o            = '0;
        ctrl_o.pick       = PICK_ZERO;
        case (mode_i)
            OP_ADD: begin
                ctrl_o.pick      = PICK_SUM;
                ctrl_o.ovf_vis   = 1'b1;
                ctrl_o.carry_vis = 1'b1;
            end
            OP_ADDU: begin
                ctrl_o.pick      = PICK_SUM;
                ctrl_o.carry_vis = 1'b1;
            end
            OP_SUB: begin
                ctrl_o.inv_b     = 1'b1;
                ctrl_o.carry_in  = 1'b1;
                ctrl_o.pick      = PICK_SUM;
                ctrl_o.ovf_vis   = 1'b1;
                ctrl_o.carry_vis = 1'b1;
            end
            OP_SUBU: begin
                ctrl_o.inv_b     = 1'b1;
                ctrl_o.carry_in  = 1'b1;
                ctrl_o.pick      = PICK_SUM;
                ctrl_o.carry_vis = 1'b1;
            end
            OP_AND: ctrl_o.pick = PICK_AND;
            OP_OR:  ctrl_o.pick = PICK_OR;
            OP_XOR: ctrl_o.pick = PICK_XOR;
            OP_NOR: begin
                ctrl_o.pick    = PICK_OR;
                ctrl_o.inv_out = 1'b1;
            end
            OP_SLT: begin
                ctrl_o.inv_b      = 1'b1;
                ctrl_o.carry_in   = 1'b1;
                ctrl_o.pick       = PICK_LESS;
                ctrl_o.signed_cmp = 1'b1;
            end
            OP_SLTU: begin
                ctrl_o.inv_b    = 1'b1;
                ctrl_o.carry_in = 1'b1;
                ctrl_o.pick     = PICK_LESS;
            end
            default: ctrl_o.pick = PICK_ZERO;
        endcase
    end

    // Guard: an inverted B always comes with a carry-in of one (two's complement negate).
    always_comb begin
        AST_NEGATE_PAIR: assert (!ctrl_o.inv_b || ctrl_o.carry_in); // R2
    end

endmodule

// File: rtl/int_alu_slice.sv
// Module: int_alu_slice
// One bit of the datapath: full adder, bitwise gates and output selector.
// Assumes less_i is tied low on every slice except bit 0.
module int_alu_slice
    import int_alu_pkg::*;
(
    input  logic        a_i,
    input  logic        b_i,
    input  logic        carry_i,
    input  logic        inv_b_i,
    input  logic        inv_out_i,
    input  slice_pick_e pick_i,
    input  logic        less_i,
    output logic        sum_o,
    output logic        carry_o,
    output logic        res_o
);

    logic b_eff;
    logic picked;

    // Full adder on A and the optionally complemented B.
    always_comb begin
        b_eff   = b_i ^ inv_b_i;
        sum_o   = a_i ^ b_eff ^ carry_i;
        carry_o = (a_i & b_eff) | (carry_i & (a_i ^ b_eff));
    end

    // Select the slice output and apply the optional complement.
    always_comb begin
        unique case (pick_i)
            PICK_SUM:  picked = sum_o;
            PICK_AND:  picked = a_i & b_i;
            PICK_OR:   picked = a_i | b_i;
            PICK_XOR:  picked = a_i ^ b_i;
            PICK_LESS: picked = less_i;
            default:   picked = 1'b0;
        endcase
        res_o = picked ^ inv_out_i;
    end

endmodule

// File: rtl/int_alu_msb.sv
// Module: int_alu_msb
// Top-bit logic: two's complement overflow and the less-than decision.
// Assumes the inputs come from the most significant slice of the adder.
module int_alu_msb (
    input  logic a_msb_i,
    input  logic b_eff_msb_i,
    input  logic carry_into_msb_i,
    input  logic carry_out_msb_i,
    input  logic sum_msb_i,
    input  logic signed_cmp_i,
    output logic ovf_raw_o,
    output logic less_o
);

    // Overflow from the carries around the top bit; less-than from sign or borrow.
    always_comb begin
        ovf_raw_o = carry_into_msb_i ^ carry_out_msb_i;
        less_o    = signed_cmp_i ? (sum_msb_i ^ ovf_raw_o) : ~carry_out_msb_i;
    end

    // Guard: overflow judged from operand and sum signs must agree with the carry rule.
    always_comb begin
        AST_MIXED_SIGN_NO_OVF: assert ((a_msb_i == b_eff_msb_i) || !ovf_raw_o); // R3
        AST_SAME_SIGN_OVF: assert ((a_msb_i != b_eff_msb_i) || (ovf_raw_o == (sum_msb_i != a_msb_i))); // R3
    end

endmodule

// File: rtl/int_alu.sv
// Module: int_alu
// Combinational integer ALU built from WIDTH bit slices, a control decoder
// and a top-bit flag unit. Assumes immediates are already expanded to WIDTH bits.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  op_a_i,
    input  logic [WIDTH-1:0]  op_b_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [WIDTH-1:0]  result_o,
    output logic              carry_o,
    output logic              ovf_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t          ctrl;
    logic [WIDTH:0]     carry_chain;
    logic [WIDTH-1:0]   sum_bits;
    logic               ovf_raw;
    logic               less_bit;
    logic               b_eff_msb;

    int_alu_dec u_dec (
        .mode_i (mode_i),
        .ctrl_o (ctrl)
    );

    // Feed the carry-in for bit 0 from the decoder.
    always_comb carry_chain[0] = ctrl.carry_in;

    // Row of identical slices; only bit 0 receives the less-than bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            always_comb less_in = less_bit;
        end else begin : g_upper
            always_comb less_in = 1'b0;
        end
        int_alu_slice u_slice (
            .a_i       (op_a_i[i]),
            .b_i       (op_b_i[i]),
            .carry_i   (carry_chain[i]),
            .inv_b_i   (ctrl.inv_b),
            .inv_out_i (ctrl.inv_out),
            .pick_i    (ctrl.pick),
            .less_i    (less_in),
            .sum_o     (sum_bits[i]),
            .carry_o   (carry_chain[i+1]),
            .res_o     (result_o[i])
        );
    end

    // Effective B sign bit as the adder sees it.
    always_comb b_eff_msb = op_b_i[MSB] ^ ctrl.inv_b;

    int_alu_msb u_msb (
        .a_msb_i          (op_a_i[MSB]),
        .b_eff_msb_i      (b_eff_msb),
        .carry_into_msb_i (carry_chain[MSB]),
        .carry_out_msb_i  (carry_chain[WIDTH]),
        .sum_msb_i        (sum_bits[MSB]),
        .signed_cmp_i     (ctrl.signed_cmp),
        .ovf_raw_o        (ovf_raw),
        .less_o           (less_bit)
    );

    // Report flags only for the codes that define them.
    always_comb begin
        carry_o = ctrl.carry_vis & carry_chain[WIDTH];
        ovf_o   = ctrl.ovf_vis & ovf_raw;
    end

    // Guard: flag masking, comparison shape and unused codes at the ports.
    always_comb begin
        AST_UNSIGNED_NO_OVF: assert (!((mode_i == OP_ADDU) || (mode_i == OP_SUBU)) || !ovf_o); // R4
        AST_LOGIC_FLAGS_CLEAR: assert (!(mode_i inside {OP_AND, OP_OR, OP_XOR, OP_NOR}) || (!carry_o && !ovf_o)); // R7
        AST_SLT_FLAGS_CLEAR: assert (!(mode_i inside {OP_SLT, OP_SLTU}) || (!carry_o && !ovf_o)); // R8
        AST_SLT_UPPER_ZERO: assert (!(mode_i inside {OP_SLT, OP_SLTU}) || (result_o[WIDTH-1:1] == '0)); // R5
        AST_SLT_USES_DIFF: assert (!(mode_i inside {OP_SLT, OP_SLTU}) || (sum_bits == op_a_i - op_b_i)); // R6
        AST_UNUSED_ZERO: assert ((mode_i <= OP_NOR) || (mode_i inside {OP_SLT, OP_SLTU}) || ((result_o == '0) && !carry_o && !ovf_o)); // R9
    end

endmodule

// File: tb/int_alu_bench.sv
// Bench for int_alu: vector table, corner sweep, random sweep against a reference model.
module int_alu_bench;

    localparam int W = 32;
    localparam int NVEC = 20;

    logic          clk = 1'b0;
    logic [W-1:0]  op_a;
    logic [W-1:0]  op_b;
    logic [3:0]    mode;
    logic [W-1:0]  result;
    logic          carry;
    logic          ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    int_alu #(.WIDTH(W)) u_int_alu (
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .mode_i   (mode),
        .result_o (result),
        .carry_o  (carry),
        .ovf_o    (ovf)
    );

    // Fields: mode, A, B, expected result, expected carry, expected overflow.
    localparam logic [101:0] VEC [NVEC] = '{
        {4'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1},
        {4'd1,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
        {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
        {4'd0,  32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
        {4'd2,  32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'd2,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1},
        {4'd3,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b0},
        {4'd2,  32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0},
        {4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0},
        {4'd5,  32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 1'b0, 1'b0},
        {4'd6,  32'hFFFFFFFF, 32'h12345678, 32'hEDCBA987, 1'b0, 1'b0},
        {4'd7,  32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'd10, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0},
        {4'd10, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b0, 1'b0},
        {4'd11, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b0},
        {4'd11, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0},
        {4'd10, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0, 1'b0},
        {4'd9,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
        {4'd15, 32'h80000000, 32'h80000000, 32'h00000000, 1'b0, 1'b0},
        {4'd11, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0, 1'b0}
    };

    // Requirement tag for the result word of a code.
    function automatic string res_tag(input logic [3:0] m);
        if (m <= 4'd1) return "R1";
        if (m <= 4'd3) return "R2";
        if (m <= 4'd7) return "R7";
        if (m == 4'd10) return "R5";
        if (m == 4'd11) return "R6";
        return "R9";
    endfunction

    // Requirement tag for the carry flag of a code.
    function automatic string carry_tag(input logic [3:0] m);
        if (m <= 4'd1) return "R1";
        if (m <= 4'd3) return "R2";
        if (m <= 4'd7) return "R7";
        if (m == 4'd10 || m == 4'd11) return "R8";
        return "R9";
    endfunction

    // Requirement tag for the overflow flag of a code.
    function automatic string ovf_tag(input logic [3:0] m);
        if (m == 4'd0 || m == 4'd2) return "R3";
        if (m == 4'd1 || m == 4'd3) return "R4";
        if (m <= 4'd7) return "R7";
        if (m == 4'd10 || m == 4'd11) return "R8";
        return "R9";
    endfunction

    // Independent reference: returns {result, carry, overflow}.
    function automatic logic [W+1:0] ref_model(input logic [3:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]   s33;
        logic [W-1:0] r;
        logic         c;
        logic         v;
        r = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'd0, 4'd1: begin
                s33 = {1'b0, a} + {1'b0, b};
                r = s33[W-1:0]; c = s33[W];
                v = (m == 4'd0) && (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'd2, 4'd3: begin
                s33 = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = s33[W-1:0]; c = s33[W];
                v = (m == 4'd2) && (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: r = ~(a | b);
            4'd10: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            4'd11: r = {{(W-1){1'b0}}, (a < b)};
            default: r = '0;
        endcase
        return {r, c, v};
    endfunction

    // Compare the three outputs with expected values, one check each.
    task automatic check_out(input logic [W-1:0] er, input logic ec, input logic ev, input string note);
        checks++;
        if (result !== er) begin
            fails++;
            $display("FAIL %s result mode=%0d a=%h b=%h actual=%h expected=%h", res_tag(mode), mode, op_a, op_b, result, er);
        end
        checks++;
        if (carry !== ec) begin
            fails++;
            $display("FAIL %s carry mode=%0d a=%h b=%h actual=%b expected=%b", carry_tag(mode), mode, op_a, op_b, carry, ec);
        end
        checks++;
        if (ovf !== ev) begin
            fails++;
            $display("FAIL %s overflow mode=%0d a=%h b=%h actual=%b expected=%b (%s)", ovf_tag(mode), mode, op_a, op_b, ovf, ev, note);
        end
    endtask

    // Drive after a rising edge, sample at the falling edge (zero latency).
    task automatic apply(input logic [3:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        mode = m; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [W-1:0] CORNER [4] = '{32'h00000000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
    localparam logic [3:0]   MODES  [10] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11};

    initial begin
        logic [W+1:0] exp_v;
        mode = '0; op_a = '0; op_b = '0;

        // Idle state: zero operands with code 0 give zero and clear flags (R1).
        @(negedge clk);
        check_out('0, 1'b0, 1'b0, "idle R1");

        // Table walk with hand-computed answers.
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][101:98], VEC[i][97:66], VEC[i][65:34]);
            check_out(VEC[i][33:2], VEC[i][1], VEC[i][0], "table");
        end

        // R10: outputs follow inputs 1 ns after they change, with no clock edge.
        @(posedge clk);
        mode = 4'd6; op_a = 32'hAAAA5555; op_b = 32'hFFFF0000;
        #1;
        checks++;
        if (result !== 32'h55555555) begin
            fails++;
            $display("FAIL R10 result actual=%h expected=%h", result, 32'h55555555);
        end

        // Unused codes ignore operands (R9): sweep all six with nonzero inputs.
        for (int k = 0; k < 16; k++) begin
            if (k == 8 || k == 9 || k >= 12) begin
                apply(4'(k), 32'h7FFFFFFF, 32'h80000001);
                check_out('0, 1'b0, 1'b0, "unused R9");
            end
        end

        // Corner operand sweep through every defined code.
        for (int mi = 0; mi < 10; mi++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    apply(MODES[mi], CORNER[ai], CORNER[bi]);
                    exp_v = ref_model(MODES[mi], CORNER[ai], CORNER[bi]);
                    check_out(exp_v[W+1:2], exp_v[1], exp_v[0], "corner");
                end
            end
        end

        // Random operands through every defined code.
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = $urandom();
            rb = $urandom();
            if (n % 5 == 0) rb = ra;
            apply(MODES[n % 10], ra, rb);
            exp_v = ref_model(MODES[n % 10], ra, rb);
            check_out(exp_v[W+1:2], exp_v[1], exp_v[0], "random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule